// File: doc/BRIEF.md
# Multi-Channel Edge Timestamp Capture

The block watches a set of already-filtered digital inputs and records when each one changes. All channels share a single free-running microsecond counter. It starts at zero when reset is released and advances by one every microsecond, so times taken on different channels can be compared directly. Each channel holds a 2-bit edge code that selects which transitions count. A transition that matches the code copies the counter into the channel's stamp register and raises a one-cycle event pulse for that channel.

Software programs the per-channel codes one configuration byte at a time. It collects results through a registered read port. Each read returns the stored stamp, a sticky "new" flag and an "overrun" flag. A stored time includes any delay of the upstream filter, and software removes that delay itself. The counter is 32 bits wide by default and wraps modulo 2^TS_W.

Top module: `edge_stamp_unit`

## Requirements
- R1: After reset the timer reads 0. It advances by exactly one each time CLK_HZ/TICK_HZ clock cycles have passed: it still reads 0 after 199 rising edges at the defaults, and reads 1 after the 200th.
- R2: Edge code 2'b01 captures on a low-to-high transition of the channel input only.
- R3: Edge code 2'b10 captures on a high-to-low transition only.
- R4: Edge code 2'b11 captures on both transitions.
- R5: Edge code 2'b00 produces no capture and no event pulse, the new flag stays 0 and the stamp is unchanged.
- R6: A configuration write of channel `cfg_ch` takes `cfg_data[1:0]` as the code and discards bits 7..2. A read returns the code in `rd_cfg[1:0]` with `rd_cfg[7:2]` equal to zero.
- R7: Each input passes two synchroniser flops before edge detection. The capture and the event pulse appear on the third rising clock edge after the input changes. The stored value is the timer value of the cycle just before that edge.
- R8: A single qualifying transition gives an event pulse that is high for exactly one cycle.
- R9: A read is requested by `rd_en` with `rd_ch`. One cycle later `rd_valid` is high and `rd_stamp`, `rd_new`, `rd_ovr` and `rd_cfg` show the channel as it was before the read. The read clears that channel's new and overrun flags.
- R10: A capture while the new flag is still set overwrites the stamp and sets the overrun flag.
- R11: If a capture and a read of the same channel fall in the same cycle, the read returns the old stamp and the capture wins. The new flag stays set, the stamp holds the new value, and the overrun flag ends up 0.
- R12: Captures on different channels in the same cycle store identical timer values.
- R13: Reset clears every stamp, flag and edge code to zero and leaves all event pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | NUM_CH | Filtered channel inputs, asynchronous to clk |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_ch | input | CH_W | Channel addressed by the configuration write |
| cfg_data | input | 8 | Configuration byte; bits 1..0 carry the edge code |
| rd_en | input | 1 | Read request |
| rd_ch | input | CH_W | Channel addressed by the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_stamp | output | TS_W | Stored timestamp of the read channel |
| rd_new | output | 1 | New-capture flag before the read |
| rd_ovr | output | 1 | Overrun flag before the read |
| rd_cfg | output | 8 | Configuration byte of the read channel |
| evt_pulse | output | NUM_CH | One-cycle event request per channel |
| time_now | output | TS_W | Current microsecond timer |

## Verification
A capture on a channel and a software read of the same channel can land on the same clock edge, and that edge decides which stamp the reader sees and what happens to the flags. The bench provokes this by holding the read request so that it meets the third clock edge after an input transition. It first lets an earlier stamp sit unread in the channel. The read data must show that earlier stamp. A second read must then show the newer stamp, the new flag still set, and no overrun.

// File: rtl/esu_pkg.sv
package esu_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_mode_e;

   localparam int CFG_BYTE_W = 8;
   localparam int CODE_W     = 2;

   function automatic logic edge_hit(input edge_mode_e mode,
                                     input logic rise,
                                     input logic fall);
      logic hit;
      unique case (mode)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/esu_tick_gen.sv
module esu_tick_gen #(
   parameter int unsigned CLK_HZ  = 200_000_000,
   parameter int unsigned TICK_HZ = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned DIV   = CLK_HZ / TICK_HZ;
   localparam int          CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV <= 1) begin : g_passthru
      assign tick = 1'b1;
   end else begin : g_divider
      logic [CNT_W-1:0] cnt_q;
      assign tick = (cnt_q == CNT_W'(DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt_q <= '0;
         else if (tick) cnt_q <= '0;
         else           cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/esu_timebase.sv
module esu_timebase #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   output logic [TS_W-1:0] now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    now <= '0;
      else if (tick) now <= now + 1'b1;
   end
endmodule

// File: rtl/esu_channel.sv
module esu_channel
   import esu_pkg::*;
#(
   parameter int TS_W        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sig_raw,
   input  logic              cfg_hit,
   input  logic [CODE_W-1:0] cfg_code,
   input  logic              rd_hit,
   input  logic [TS_W-1:0]   now,
   output logic [CODE_W-1:0] code_o,
   output logic [TS_W-1:0]   stamp_q,
   output logic              new_q,
   output logic              ovr_q,
   output logic              evt_q
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   synced;
   logic                   rise;
   logic                   fall;
   logic                   hit;
   edge_mode_e             mode_q;

   assign synced = sync_q[SYNC_STAGES-1];
   assign rise   = synced & ~prev_q;
   assign fall   = ~synced & prev_q;
   assign hit    = edge_hit(mode_q, rise, fall);
   assign code_o = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], sig_raw};
         prev_q <= synced;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= EDGE_OFF;
      else if (cfg_hit) mode_q <= edge_mode_e'(cfg_code);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stamp_q <= '0;
         new_q   <= 1'b0;
         ovr_q   <= 1'b0;
         evt_q   <= 1'b0;
      end else begin
         evt_q <= hit;
         if (hit) begin
            stamp_q <= now;
            new_q   <= 1'b1;
            ovr_q   <= rd_hit ? 1'b0 : (ovr_q | new_q);
         end else if (rd_hit) begin
            new_q <= 1'b0;
            ovr_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/esu_read_port.sv
module esu_read_port
   import esu_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int TS_W   = 32,
   parameter int CH_W   = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd_en,
   input  logic [CH_W-1:0]               rd_ch,
   input  logic [NUM_CH-1:0][TS_W-1:0]   stamps,
   input  logic [NUM_CH-1:0]             news,
   input  logic [NUM_CH-1:0]             ovrs,
   input  logic [NUM_CH-1:0][CODE_W-1:0] codes,
   output logic                          rd_valid,
   output logic [TS_W-1:0]               rd_stamp,
   output logic                          rd_new,
   output logic                          rd_ovr,
   output logic [CFG_BYTE_W-1:0]         rd_cfg
);
   logic [TS_W-1:0]   stamp_mux;
   logic              new_mux;
   logic              ovr_mux;
   logic [CODE_W-1:0] code_mux;

   always_comb begin
      stamp_mux = '0;
      new_mux   = 1'b0;
      ovr_mux   = 1'b0;
      code_mux  = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_ch == CH_W'(i)) begin
            stamp_mux = stamps[i];
            new_mux   = news[i];
            ovr_mux   = ovrs[i];
            code_mux  = codes[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_stamp <= '0;
         rd_new   <= 1'b0;
         rd_ovr   <= 1'b0;
         rd_cfg   <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            rd_stamp <= stamp_mux;
            rd_new   <= new_mux;
            rd_ovr   <= ovr_mux;
            rd_cfg   <= {{(CFG_BYTE_W-CODE_W){1'b0}}, code_mux};
         end
      end
   end
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
   import esu_pkg::*;
#(
   parameter int          NUM_CH      = 16,
   parameter int unsigned CLK_HZ      = 200_000_000,
   parameter int unsigned TICK_HZ     = 1_000_000,
   parameter int          TS_W        = 32,
   parameter int          SYNC_STAGES = 2,
   localparam int         CH_W        = $clog2(NUM_CH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CH-1:0]     sig_in,
   input  logic                  cfg_we,
   input  logic [CH_W-1:0]       cfg_ch,
   input  logic [CFG_BYTE_W-1:0] cfg_data,
   input  logic                  rd_en,
   input  logic [CH_W-1:0]       rd_ch,
   output logic                  rd_valid,
   output logic [TS_W-1:0]       rd_stamp,
   output logic                  rd_new,
   output logic                  rd_ovr,
   output logic [CFG_BYTE_W-1:0] rd_cfg,
   output logic [NUM_CH-1:0]     evt_pulse,
   output logic [TS_W-1:0]       time_now
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("edge_stamp_unit: NUM_CH must be 2 or more");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_stamp_unit: SYNC_STAGES must be 2 or more");
   end
   if (CLK_HZ < TICK_HZ || TICK_HZ == 0) begin : g_bad_rate
      $error("edge_stamp_unit: CLK_HZ must be at least TICK_HZ");
   end
   if (TS_W < 2) begin : g_bad_ts
      $error("edge_stamp_unit: TS_W must be 2 or more");
   end

   logic                          us_tick;
   logic [NUM_CH-1:0][TS_W-1:0]   stamp_vec;
   logic [NUM_CH-1:0]             new_vec;
   logic [NUM_CH-1:0]             ovr_vec;
   logic [NUM_CH-1:0][CODE_W-1:0] code_vec;

   esu_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (us_tick)
   );

   esu_timebase #(.TS_W(TS_W)) u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (us_tick),
      .now   (time_now)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic cfg_sel;
      logic rd_sel;
      assign cfg_sel = cfg_we && (cfg_ch == CH_W'(c));
      assign rd_sel  = rd_en  && (rd_ch  == CH_W'(c));

      esu_channel #(.TS_W(TS_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .sig_raw  (sig_in[c]),
         .cfg_hit  (cfg_sel),
         .cfg_code (cfg_data[CODE_W-1:0]),
         .rd_hit   (rd_sel),
         .now      (time_now),
         .code_o   (code_vec[c]),
         .stamp_q  (stamp_vec[c]),
         .new_q    (new_vec[c]),
         .ovr_q    (ovr_vec[c]),
         .evt_q    (evt_pulse[c])
      );
   end

   esu_read_port #(.NUM_CH(NUM_CH), .TS_W(TS_W), .CH_W(CH_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_ch    (rd_ch),
      .stamps   (stamp_vec),
      .news     (new_vec),
      .ovrs     (ovr_vec),
      .codes    (code_vec),
      .rd_valid (rd_valid),
      .rd_stamp (rd_stamp),
      .rd_new   (rd_new),
      .rd_ovr   (rd_ovr),
      .rd_cfg   (rd_cfg)
   );
endmodule

// File: rtl/esu_checker.sv
module esu_checker #(
   parameter int NUM_CH = 16,
   parameter int TS_W   = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [TS_W-1:0]             time_now,
   input logic [NUM_CH-1:0]           evt_pulse,
   input logic [NUM_CH-1:0]           new_vec,
   input logic [NUM_CH-1:0]           ovr_vec,
   input logic [NUM_CH-1:0][1:0]      code_vec,
   input logic [NUM_CH-1:0][TS_W-1:0] stamp_vec,
   input logic                        rd_en,
   input logic                        rd_valid,
   input logic [7:0]                  rd_cfg
);
   // R1: the timer only ever moves forward by one
   assert_timer_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (time_now != $past(time_now)) |-> (time_now == $past(time_now) + 1'b1));

   // R9: read data valid exactly one cycle after a request
   assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   // R6: reserved configuration bits never read back as ones
   assert_cfg_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_cfg[7:2] == 6'b0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_prop
      // R5: a disabled channel raises no event
      assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(code_vec[i]) == 2'b00) |-> !evt_pulse[i]);
      // R9: every event leaves the new flag set
      assert_evt_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
         evt_pulse[i] |-> new_vec[i]);
      // R10: overrun only rises over an unread capture
      assert_ovr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovr_vec[i]) |-> $past(new_vec[i]));
      // R12: simultaneous captures share one time value
      assert_same_time_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_pulse[i] && evt_pulse[0]) |-> (stamp_vec[i] == stamp_vec[0]));
   end
endmodule

bind edge_stamp_unit esu_checker #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_esu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .time_now  (time_now),
   .evt_pulse (evt_pulse),
   .new_vec   (new_vec),
   .ovr_vec   (ovr_vec),
   .code_vec  (code_vec),
   .stamp_vec (stamp_vec),
   .rd_en     (rd_en),
   .rd_valid  (rd_valid),
   .rd_cfg    (rd_cfg)
);

// File: tb/edge_stamp_unit_test.sv
`timescale 1ns/1ps
module edge_stamp_unit_test;
   localparam int NCH = 16;
   localparam int DIV = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sig = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_ch = '0;
   logic [7:0]  cfg_data = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_ch = '0;
   logic        rd_valid;
   logic [31:0] rd_stamp;
   logic        rd_new;
   logic        rd_ovr;
   logic [7:0]  rd_cfg;
   logic [15:0] evt_pulse;
   logic [31:0] time_now;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   edge_stamp_unit uut (
      .clk(clk), .rst_n(rst_n), .sig_in(sig),
      .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_data(cfg_data),
      .rd_en(rd_en), .rd_ch(rd_ch),
      .rd_valid(rd_valid), .rd_stamp(rd_stamp), .rd_new(rd_new),
      .rd_ovr(rd_ovr), .rd_cfg(rd_cfg),
      .evt_pulse(evt_pulse), .time_now(time_now)
   );

   // row: channel, edge code, starting level, new level, capture expected
   localparam logic [8:0] VEC [10] = '{
      {4'd0,  2'b01, 1'b0, 1'b1, 1'b1},
      {4'd1,  2'b01, 1'b1, 1'b0, 1'b0},
      {4'd2,  2'b10, 1'b1, 1'b0, 1'b1},
      {4'd3,  2'b10, 1'b0, 1'b1, 1'b0},
      {4'd4,  2'b11, 1'b0, 1'b1, 1'b1},
      {4'd5,  2'b11, 1'b1, 1'b0, 1'b1},
      {4'd6,  2'b00, 1'b0, 1'b1, 1'b0},
      {4'd7,  2'b00, 1'b1, 1'b0, 1'b0},
      {4'd15, 2'b01, 1'b0, 1'b1, 1'b1},
      {4'd9,  2'b11, 1'b1, 1'b0, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input int ch, input logic [7:0] val);
      cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_data = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_read(input int ch);
      rd_en = 1'b1; rd_ch = 4'(ch);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(negedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] t_a, t_b;
      string req;
      repeat (3) @(negedge clk);
      chk(time_now == 0, "R13", "timer in reset", time_now, 0);
      chk(evt_pulse == 0, "R13", "events in reset", 32'(evt_pulse), 0);
      chk(rd_valid == 0, "R13", "rd_valid in reset", 32'(rd_valid), 0);
      rst_n = 1'b1;

      // R1: tick period
      repeat (DIV - 1) @(negedge clk);
      chk(time_now == 0, "R1", "timer before first tick", time_now, 0);
      @(negedge clk);
      chk(time_now == 1, "R1", "timer after first tick", time_now, 1);
      repeat (DIV) @(negedge clk);
      chk(time_now == 2, "R1", "timer after second tick", time_now, 2);

      // R13: all channels clear after reset
      for (int c = 0; c < NCH; c++) begin
         do_read(c);
         chk(rd_stamp == 0 && rd_new == 0 && rd_ovr == 0 && rd_cfg == 0,
             "R13", "channel state after reset", rd_stamp | 32'(rd_cfg), 0);
      end

      // table walk: R2..R5, R7, R8, R9
      for (int r = 0; r < 10; r++) begin
         int ch;
         logic [1:0] code;
         logic l0, l1, ex;
         {ch, code, l0, l1, ex} = {28'd0, VEC[r]};
         case (code)
            2'b01:   req = "R2";
            2'b10:   req = "R3";
            2'b11:   req = "R4";
            default: req = "R5";
         endcase
         sig[ch] = l0;
         repeat (4) @(negedge clk);
         do_read(ch);
         cfg_write(ch, {6'b0, code});
         sig[ch] = l1;
         @(negedge clk); @(negedge clk);
         chk(evt_pulse[ch] == 0, "R7", "no event before third edge", 32'(evt_pulse[ch]), 0);
         t_a = time_now;
         @(negedge clk);
         chk(evt_pulse[ch] == ex, req, "event on third edge", 32'(evt_pulse[ch]), 32'(ex));
         @(negedge clk);
         chk(evt_pulse[ch] == 0, "R8", "event lasts one cycle", 32'(evt_pulse[ch]), 0);
         do_read(ch);
         chk(rd_valid == 1, "R9", "rd_valid after read", 32'(rd_valid), 1);
         chk(rd_new == ex, req, "new flag", 32'(rd_new), 32'(ex));
         chk(rd_stamp == (ex ? t_a : 32'd0), "R7", "stored stamp", rd_stamp, ex ? t_a : 32'd0);
         do_read(ch);
         chk(rd_new == 0, "R9", "new cleared by read", 32'(rd_new), 0);
      end

      // R6: reserved bits discarded
      cfg_write(10, 8'hFD);
      do_read(10);
      chk(rd_cfg == 8'h01, "R6", "config readback", 32'(rd_cfg), 32'h01);
      cfg_write(10, 8'h00);

      // R10: overrun on channel 4 (code 11, level 1)
      sig[4] = 1'b0;
      repeat (3) @(negedge clk);
      repeat (250) @(negedge clk);
      sig[4] = 1'b1;
      @(negedge clk); @(negedge clk);
      t_b = time_now;
      @(negedge clk);
      do_read(4);
      chk(rd_new == 1 && rd_ovr == 1, "R10", "overrun flag set", {rd_new, rd_ovr}, 32'h3);
      chk(rd_stamp == t_b, "R10", "stamp overwritten", rd_stamp, t_b);
      do_read(4);
      chk(rd_new == 0 && rd_ovr == 0, "R9", "flags cleared", {rd_new, rd_ovr}, 0);

      // R11: capture and read collide on channel 5 (code 11, level 0)
      sig[5] = 1'b1;
      @(negedge clk); @(negedge clk);
      t_a = time_now;
      @(negedge clk);
      repeat (250) @(negedge clk);
      sig[5] = 1'b0;
      @(negedge clk); @(negedge clk);
      t_b = time_now;
      rd_en = 1'b1; rd_ch = 4'd5;
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_stamp == t_a, "R11", "collision read returns old stamp", rd_stamp, t_a);
      chk(rd_new == 1, "R11", "collision read sees old new flag", 32'(rd_new), 1);
      do_read(5);
      chk(rd_new == 1, "R11", "new flag survives collision", 32'(rd_new), 1);
      chk(rd_ovr == 0, "R11", "no overrun after collision", 32'(rd_ovr), 0);
      chk(rd_stamp == t_b, "R11", "stamp holds new capture", rd_stamp, t_b);

      // R12: channels 0 and 15 (code 01) rise together
      sig[0] = 1'b0; sig[15] = 1'b0;
      repeat (4) @(negedge clk);
      sig[0] = 1'b1; sig[15] = 1'b1;
      @(negedge clk); @(negedge clk);
      t_a = time_now;
      @(negedge clk);
      chk(evt_pulse[0] && evt_pulse[15], "R12", "both events", 32'(evt_pulse), 32'h8001);
      do_read(0);
      chk(rd_stamp == t_a, "R12", "channel 0 stamp", rd_stamp, t_a);
      do_read(15);
      chk(rd_stamp == t_a, "R12", "channel 15 stamp", rd_stamp, t_a);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule